// File: doc/BRIEF.md
# Triggered Capture Recorder

The recorder keeps a window of a sample stream around a trigger event. A start strobe latches the configuration, empties the store and arms the block. While armed, the most recent words are kept in a circular store up to a programmed pre-trigger count. Once that many words are held, a trigger seen on a valid sample is accepted. Recording then goes on until a programmed total number of words is stored, and the done flag rises.

The stored words are read out in time order through a pop port. It offers an empty flag, the current word with a flag that marks it as a run count, and a pop strobe that moves to the next word. An optional run-length mode, latched at start, replaces repeats of a sample with count words. Because of this, the pre-trigger count and the total length are counted in stored words.

Top module: `capture_recorder`

## Requirements
- R1: After reset, done is 0 and rd_empty is 1, and samples are ignored until the first start.
- R2: A start strobe latches pre_count, total_len and rle_mode. In the next cycle done is 0 and rd_empty is 1, and any words left unread are discarded.
- R3: Before the trigger, only the newest pre_count stored words are kept. Readout begins with these, oldest first.
- R4: A trigger is accepted only on a cycle with smp_valid high, after start, once pre_count words are held. A trigger seen before that is ignored.
- R5: From the trigger sample on, words are stored until exactly total_len words are held. Words beyond that are dropped, even the second word of a two-word cycle.
- R6: done rises in the cycle after the word that fills total_len, or in the cycle after an accepted trigger when pre_count equals total_len. Later samples and triggers leave the store unchanged until the next start.
- R7: While done is 1 and words remain, rd_empty is 0 and rd_word shows the oldest unread word. rd_pop moves to the next word. A pop while rd_empty is 1 or while capture runs has no effect.
- R8: With rle_mode 0, each valid sample stores one word with rd_is_count 0 and the sample as data.
- R9: With rle_mode 1, a sample equal to the previous one stores nothing and is counted. When a different sample arrives, a word with rd_is_count 1 is stored first if the count is nonzero, holding the count in its low bits. The new sample is then stored as a word with rd_is_count 0.
- R10: A run count saturates at 2^RUN_W-1 (15 by default). On reaching it, a count word with that value is stored at once and counting restarts from zero for the same value.
- R11: The accepted trigger sample always closes the open run, even if it repeats the previous value. The words stored in its cycle (pending count first, then its literal) are the first post-trigger words.
- R12: total_len is clamped to DEPTH (32), and pre_count is clamped to the clamped total_len.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm strobe; latches configuration and empties the store |
| pre_count | input | CW (6) | Words kept from before the trigger |
| total_len | input | CW (6) | Total words to store |
| rle_mode | input | 1 | 1 enables run-length encoding |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | DATA_W (16) | Sample value |
| trig | input | 1 | Trigger event, qualified by smp_valid |
| done | output | 1 | Capture complete |
| rd_empty | output | 1 | No unread word available |
| rd_word | output | DATA_W (16) | Oldest unread word (value or count) |
| rd_is_count | output | 1 | 1 when rd_word is a run count |
| rd_pop | input | 1 | Advance to the next stored word |

## Verification
A wrong fill count or write pointer shows up as soon as readout begins. The first word read is then either the wrong pre-trigger word, or the number of words before rd_empty rises differs from total_len. A trigger accepted too early shortens the pre-trigger part and shifts every word after it. A bad run counter in the encoder changes a count word's value, or puts a count word where the bench expects a literal. The done flag is compared in every cycle, so completing one cycle early or late fails in the cycle where it happens.

// File: rtl/cr_pkg.sv
package cr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cr_state_e;

  // smaller of a value and a limit
  function automatic int clamp_to(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  // add with an upper cap, used for the pre-trigger window
  function automatic int cap_add(input int base, input int add, input int lim);
    return (base + add > lim) ? lim : base + add;
  endfunction

  // how many of the offered words fit in the remaining room
  function automatic int take_words(input int offered, input int room);
    return (offered > room) ? room : offered;
  endfunction

endpackage

// File: rtl/cr_rle_enc.sv
module cr_rle_enc #(
  parameter int DATA_W = 16,
  parameter int RUN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rle_en,
  input  logic              smp_en,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              force_brk,
  output logic [1:0]        out_n,
  output logic [DATA_W:0]   out_w0,
  output logic [DATA_W:0]   out_w1
);

  localparam logic [RUN_W-1:0] REP_MAX = '1;

  logic              have_q, have_n;
  logic [DATA_W-1:0] ref_q, ref_n;
  logic [RUN_W-1:0]  rep_q, rep_n;
  logic [RUN_W-1:0]  rep_inc;
  logic              repeat_hit;
  logic              sat_hit;

  assign rep_inc    = rep_q + 1'b1;
  assign repeat_hit = have_q && (smp_data == ref_q) && !force_brk;
  assign sat_hit    = repeat_hit && (rep_inc == REP_MAX);

  always_comb begin
    have_n = have_q;
    ref_n  = ref_q;
    rep_n  = rep_q;
    out_n  = 2'd0;
    out_w0 = '0;
    out_w1 = '0;
    if (smp_en) begin
      if (!rle_en) begin
        out_n  = 2'd1;
        out_w0 = {1'b0, smp_data};
      end else if (repeat_hit) begin
        if (sat_hit) begin
          out_n  = 2'd1;
          out_w0 = {1'b1, DATA_W'(REP_MAX)};
          rep_n  = '0;
        end else begin
          rep_n = rep_inc;
        end
      end else begin
        if (rep_q != '0) begin
          out_n  = 2'd2;
          out_w0 = {1'b1, DATA_W'(rep_q)};
          out_w1 = {1'b0, smp_data};
        end else begin
          out_n  = 2'd1;
          out_w0 = {1'b0, smp_data};
        end
        have_n = 1'b1;
        ref_n  = smp_data;
        rep_n  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_q <= 1'b0;
      ref_q  <= '0;
      rep_q  <= '0;
    end else begin
      have_q <= have_n;
      ref_q  <= ref_n;
      rep_q  <= rep_n;
    end
  end

  // literal mode stores exactly one value word per sample
  p_lit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !rle_en) |-> (out_n == 2'd1 && !out_w0[DATA_W]));

  // run counter never rests at the saturation value
  p_rep_below_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q != REP_MAX);

  // a two-word cycle is a count followed by a literal
  p_pair_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_n == 2'd2) |-> (out_w0[DATA_W] && !out_w1[DATA_W]));

  // the trigger sample always closes the run
  p_brk_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && rle_en && force_brk) |=> (rep_q == '0));

endmodule

// File: rtl/cr_ring.sv
module cr_ring #(
  parameter int WORD_W = 17,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_n,
  input  logic [WORD_W-1:0] wr_w0,
  input  logic [WORD_W-1:0] wr_w1,
  input  logic [$clog2(DEPTH):0] back,
  output logic [WORD_W-1:0] rd_w
);

  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q;
  logic [AW-1:0]     wp_nxt1;
  logic [AW-1:0]     rd_addr;

  assign wp_nxt1 = wp_q + 1'b1;
  assign rd_addr = wp_q - back[AW-1:0];
  assign rd_w    = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_n != 2'd0) mem[wp_q] <= wr_w0;
    if (wr_n == 2'd2) mem[wp_nxt1] <= wr_w1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_q + AW'(wr_n);
  end

  // the store never reaches back further than its depth
  p_back_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    back <= ($clog2(DEPTH)+1)'(DEPTH));

endmodule

// File: rtl/cr_ctrl.sv
module cr_ctrl #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] pre_in,
  input  logic [CW-1:0] len_in,
  input  logic          rle_in,
  input  logic          smp_valid,
  input  logic          trig,
  input  logic          pop,
  input  logic [1:0]    enc_n,
  output logic          enc_en,
  output logic          enc_brk,
  output logic          rle_q,
  output logic [1:0]    wr_n,
  output logic [CW-1:0] fill,
  output logic          done,
  output logic          empty
);

  import cr_pkg::*;

  cr_state_e     st_q, st_n;
  logic [CW-1:0] off_q, len_q;
  logic [CW-1:0] fill_q, fill_n;
  logic [CW-1:0] room;
  logic [CW-1:0] len_clamped, off_clamped;
  logic          capturing;
  logic          trig_ok;
  logic          post_path;
  logic          reach_len;

  assign len_clamped = CW'(clamp_to(int'(len_in), DEPTH));
  assign off_clamped = CW'(clamp_to(int'(pre_in), int'(len_clamped)));

  assign capturing = (st_q == ST_PRE) || (st_q == ST_POST);
  assign enc_en    = smp_valid && capturing && !start;
  assign trig_ok   = enc_en && (st_q == ST_PRE) && trig && (fill_q == off_q);
  assign enc_brk   = trig_ok;
  assign post_path = trig_ok || (enc_en && st_q == ST_POST);
  assign room      = len_q - fill_q;
  assign reach_len = post_path && (CW'(enc_n) >= room);

  always_comb begin
    st_n   = st_q;
    fill_n = fill_q;
    wr_n   = 2'd0;
    if (post_path) begin
      wr_n   = 2'(take_words(int'(enc_n), int'(room)));
      fill_n = fill_q + CW'(wr_n);
      if (reach_len) st_n = ST_DONE;
      else           st_n = ST_POST;
    end else if (st_q == ST_PRE) begin
      wr_n   = enc_n;
      fill_n = CW'(cap_add(int'(fill_q), int'(enc_n), int'(off_q)));
    end else if (st_q == ST_DONE) begin
      if (pop && fill_q != '0) fill_n = fill_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fill_q <= '0;
      off_q  <= '0;
      len_q  <= '0;
      rle_q  <= 1'b0;
    end else if (start) begin
      st_q   <= ST_PRE;
      fill_q <= '0;
      off_q  <= off_clamped;
      len_q  <= len_clamped;
      rle_q  <= rle_in;
    end else begin
      st_q   <= st_n;
      fill_q <= fill_n;
    end
  end

  assign fill  = fill_q;
  assign done  = (st_q == ST_DONE);
  assign empty = !((st_q == ST_DONE) && (fill_q != '0));

  p_len_clamp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q <= CW'(DEPTH)) && (off_q <= len_q));

  p_fill_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= len_q);

  p_pre_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRE) |-> (fill_q <= off_q));

  // leaving the pre phase needs a full pre-trigger window
  p_trig_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_POST || st_q == ST_DONE) && $past(st_q == ST_PRE) && !$past(start))
      |-> ($past(fill_q) == $past(off_q)));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !start) |=> (st_q == ST_DONE));

  p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && pop && fill_q != '0 && !start) |=> (fill_q == $past(fill_q) - 1'b1));

  p_busy_pop_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST && !start && !smp_valid) |=> $stable(fill_q));

endmodule

// File: rtl/capture_recorder.sv
module capture_recorder #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int RUN_W  = 4,
  parameter int CW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     pre_count,
  input  logic [CW-1:0]     total_len,
  input  logic              rle_mode,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig,
  output logic              done,
  output logic              rd_empty,
  output logic [DATA_W-1:0] rd_word,
  output logic              rd_is_count,
  input  logic              rd_pop
);

  localparam int WORD_W = DATA_W + 1;

  logic              enc_en;
  logic              enc_brk;
  logic              rle_q;
  logic [1:0]        enc_n;
  logic [WORD_W-1:0] enc_w0, enc_w1;
  logic [1:0]        wr_n;
  logic [CW-1:0]     fill;
  logic [WORD_W-1:0] head_w;

  cr_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pre_in   (pre_count),
    .len_in   (total_len),
    .rle_in   (rle_mode),
    .smp_valid(smp_valid),
    .trig     (trig),
    .pop      (rd_pop),
    .enc_n    (enc_n),
    .enc_en   (enc_en),
    .enc_brk  (enc_brk),
    .rle_q    (rle_q),
    .wr_n     (wr_n),
    .fill     (fill),
    .done     (done),
    .empty    (rd_empty)
  );

  cr_rle_enc #(.DATA_W(DATA_W), .RUN_W(RUN_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .rle_en   (rle_q),
    .smp_en   (enc_en),
    .smp_data (smp_data),
    .force_brk(enc_brk),
    .out_n    (enc_n),
    .out_w0   (enc_w0),
    .out_w1   (enc_w1)
  );

  cr_ring #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_n (wr_n),
    .wr_w0(enc_w0),
    .wr_w1(enc_w1),
    .back (fill),
    .rd_w (head_w)
  );

  assign rd_word     = head_w[DATA_W-1:0];
  assign rd_is_count = head_w[DATA_W];

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && rd_empty));

  p_busy_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> rd_empty);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(start)) |-> (!done && rd_empty));

endmodule

// File: tb/capture_recorder_tb.sv
`timescale 1ns/1ps
module capture_recorder_tb;

  localparam int DW = 16;
  localparam int DEPTH = 32;
  localparam int CW = 6;
  localparam int RUN_TOP = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] pre_count = '0;
  logic [CW-1:0] total_len = '0;
  logic rle_mode = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic trig = 1'b0;
  logic done, rd_empty, rd_is_count;
  logic [DW-1:0] rd_word;
  logic rd_pop = 1'b0;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  capture_recorder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_count(pre_count),
    .total_len(total_len), .rle_mode(rle_mode), .smp_valid(smp_valid),
    .smp_data(smp_data), .trig(trig), .done(done), .rd_empty(rd_empty),
    .rd_word(rd_word), .rd_is_count(rd_is_count), .rd_pop(rd_pop)
  );

  // model state
  int m_off, m_len, m_phase;
  bit m_rle, m_have;
  logic [DW-1:0] m_ref;
  int m_rep;
  logic [DW:0] hist[$];
  logic [DW:0] wq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int smaller(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // word production for one sample (R8 R9 R10 R11)
  task automatic model_words(input logic [DW-1:0] d, input bit closes);
    wq.delete();
    if (!m_rle) begin
      wq.push_back({1'b0, d});
    end else if (m_have && d == m_ref && !closes) begin
      m_rep = m_rep + 1;
      if (m_rep == RUN_TOP) begin
        wq.push_back({1'b1, 16'(RUN_TOP)});
        m_rep = 0;
      end
    end else begin
      if (m_rep != 0) wq.push_back({1'b1, 16'(m_rep)});
      wq.push_back({1'b0, d});
      m_have = 1'b1;
      m_ref = d;
      m_rep = 0;
    end
  endtask

  task automatic model_step(input bit v, input logic [DW-1:0] d, input bit t);
    bit take;
    if (m_phase == 2 || !v) return;
    take = (m_phase == 0) && t && (hist.size() == m_off);
    model_words(d, take);
    if (m_phase == 0 && !take) begin
      foreach (wq[i]) hist.push_back(wq[i]);
      while (hist.size() > m_off) void'(hist.pop_front());
    end else begin
      m_phase = 1;
      foreach (wq[i]) if (hist.size() < m_len) hist.push_back(wq[i]);
      if (hist.size() == m_len) m_phase = 2;
    end
  endtask

  task automatic run_case(input int off, input int len, input bit rle, input int dmode,
                          input int t_from, input bit t_all, input bit pop_noise,
                          input int read_lim, input string req);
    int extra;
    bit v, t;
    logic [DW-1:0] d;
    int nread;
    @(negedge clk);
    start = 1'b1; pre_count = CW'(off); total_len = CW'(len); rle_mode = rle;
    smp_valid = 1'b0; trig = 1'b0; rd_pop = 1'b0;
    m_len = smaller(len, DEPTH);
    m_off = smaller(off, m_len);
    m_rle = rle; m_have = 1'b0; m_rep = 0; m_phase = 0; hist.delete();
    @(negedge clk);
    start = 1'b0;
    chk(!done && rd_empty, "R2 start clears", {done, rd_empty}, 2'b01);
    extra = 0;
    for (int c = 0; c < 600 && extra < 6; c++) begin
      v = ($urandom % 8) != 0;
      case (dmode)
        0: d = 16'($urandom);
        1: d = 16'($urandom % 3);
        default: d = 16'h00a5;
      endcase
      t = (c >= t_from) && (t_all || ($urandom % 5) == 0);
      smp_valid = v; smp_data = d; trig = t;
      rd_pop = pop_noise && (m_phase != 2) && ($urandom % 2 == 1);
      model_step(v, d, t);
      @(negedge clk);
      chk(done == (m_phase == 2), {req, " R6 done flag"}, done, m_phase == 2);
      if (m_phase == 2) extra++;
    end
    smp_valid = 1'b0; trig = 1'b0; rd_pop = 1'b0;
    if (m_phase != 2) return;
    // R7 ordered readout; R3 R5 content
    nread = (read_lim < 0) ? hist.size() : smaller(read_lim, hist.size());
    for (int i = 0; i < nread; i++) begin
      chk(!rd_empty, {req, " R7 word available"}, rd_empty, 0);
      chk({rd_is_count, rd_word} == hist[i], {req, " R3 R5 word"}, {rd_is_count, rd_word}, hist[i]);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    if (read_lim < 0) begin
      chk(rd_empty && done, {req, " R5 length end"}, {done, rd_empty}, 2'b11);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      chk(rd_empty && done, "R7 pop on empty ignored", {done, rd_empty}, 2'b11);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, samples ignored before start
    smp_valid = 1'b1; trig = 1'b1; smp_data = 16'h1234;
    repeat (3) @(negedge clk);
    chk(!done && rd_empty, "R1 reset state", {done, rd_empty}, 2'b01);
    smp_valid = 1'b0; trig = 1'b0;

    run_case(5, 12, 1'b0, 0, 20, 1'b1, 1'b0, -1, "R3 R8");
    run_case(10, 20, 1'b0, 0, 0, 1'b1, 1'b1, -1, "R4 R7");
    run_case(6, 24, 1'b1, 1, 30, 1'b0, 1'b0, -1, "R9 R11");
    run_case(2, 8, 1'b1, 2, 40, 1'b1, 1'b0, -1, "R10");
    run_case(50, 63, 1'b0, 0, 10, 1'b0, 1'b0, -1, "R12");
    run_case(3, 3, 1'b0, 0, 5, 1'b1, 1'b0, -1, "R6 off eq len");
    run_case(4, 16, 1'b1, 1, 8, 1'b0, 1'b0, 3, "R2 partial");
    // R2: re-arm discards the 13 words left unread
    run_case(0, 6, 1'b0, 0, 2, 1'b1, 1'b0, -1, "R2 rearm");
    for (int k = 0; k < 6; k++) begin
      run_case(int'($urandom % 40), int'($urandom % 40), 1'($urandom), int'($urandom % 3),
               int'($urandom % 60), 1'($urandom), 1'($urandom), -1, "R5 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule